// File: doc/BRIEF.md
# Parallel-Group Instruction Dispatcher

This block sits between instruction fetch and the functional units of a wide-issue core. Fetch hands it an aligned fetch packet of eight 32-bit instruction words at a time. The dispatcher cuts the packet into parallel groups by reading a chaining bit in every word. It sends one group per cycle to eight functional-unit slots, placing each word in the slot that the word's unit-select field names.

A fetch packet can arrive with a start offset. This covers a branch target inside a packet: words before the offset are never dispatched. A redirect input drops whatever is left of the current packet. The ready signal to fetch rises only when the buffered packet is spent, or while its final group is going out. When two words of one group name the same unit, a conflict flag is raised together with that group's slots.

Top module: `vliw_dispatch`

## Requirements
- R1: After reset, and before any fetch packet has been accepted, every bit of `slot_valid_o` is low, `conflict_o` is low and `fp_ready_o` is high.
- R2: Word i of `fp_words_i` occupies bits [32*i+31 : 32*i]. Bit 0 of each word is its chaining bit. A 1 puts word i+1 in the same group, and a 0 closes the group at word i. Groups go out one per cycle in rising word order. The first group's slots are valid after the clock edge that follows the edge accepting the packet.
- R3: Word 7 always closes its group, even when its chaining bit is 1. A group never takes words from two fetch packets.
- R4: Bits [3:1] of a word select its slot. Values 0 through 7 mean L1, S1, M1, D1, L2, S2, M2, D2, which are slots 0 to 7. Slot k drives the whole 32-bit word on `slot_word_o[32*k+31 : 32*k]` and raises `slot_valid_o[k]`.
- R5: Dispatch begins at the word given by `fp_start_i` when the packet is accepted. Words below that index are never dispatched.
- R6: When two or more words of one group select the same slot, `conflict_o` is high in the cycle those slots are presented. The lowest-indexed of those words keeps the slot, and the others are dropped.
- R7: `fp_ready_o` is high while no packet is buffered, while the group being dispatched contains word 7, or while `redirect_i` is high. A packet is accepted on a clock edge where `fp_valid_i` and `fp_ready_o` are both high.
- R8: A clock edge with `redirect_i` high dispatches nothing and discards the buffered packet's remaining groups. If a packet is accepted on the same edge, that packet takes the buffer's place.
- R9: After any clock edge on which no group is dispatched, every bit of `slot_valid_o` and `conflict_o` is low. Slots do not hold over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fp_valid_i | input | 1 | Fetch packet offered |
| fp_ready_o | output | 1 | Dispatcher can take a fetch packet this cycle |
| fp_words_i | input | 256 | Eight instruction words, word i at bits 32*i upward |
| fp_start_i | input | 3 | Index of the first word to dispatch (branch target) |
| redirect_i | input | 1 | Drop the remaining groups of the buffered packet |
| slot_valid_o | output | 8 | Per-unit valid, slot order L1 S1 M1 D1 L2 S2 M2 D2 |
| slot_word_o | output | 256 | Per-unit instruction word, slot k at bits 32*k upward |
| conflict_o | output | 1 | Two words of the presented group selected the same unit |

## Verification
The bench builds the block with its default parameters: eight words of 32 bits, eight units, and a unit field starting at bit 1. At these values the two index spaces are the same size. Every start offset from 0 to 7, every slot and every group length from one to eight words can therefore be reached with a handful of packets. The table covers the following cases:
- single-word groups;
- one eight-word group whose last chaining bit is set;
- mixed group lengths;
- starts in the middle of a packet and on the last word;
- repeated unit selections.

Directed cases then cover a flush on its own, a flush combined with a new packet, and a packet that arrives while the final group of the previous one is going out.

// File: rtl/vd_pkg.sv
package vd_pkg;
  // Position of the chaining bit inside every instruction word.
  localparam int unsigned PBIT_POS = 0;

  // Slot numbering selected by the unit field.
  typedef enum logic [2:0] {
    UNIT_L1 = 3'd0,
    UNIT_S1 = 3'd1,
    UNIT_M1 = 3'd2,
    UNIT_D1 = 3'd3,
    UNIT_L2 = 3'd4,
    UNIT_S2 = 3'd5,
    UNIT_M2 = 3'd6,
    UNIT_D2 = 3'd7
  } unit_e;
endpackage

// File: rtl/vd_rst_sync.sv
module vd_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/vd_packet_buf.sv
module vd_packet_buf #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WW    = 32,
  localparam int unsigned PW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [WORDS*WW-1:0] words_i,
  input  logic [PW-1:0]       start_i,
  input  logic                flush_i,
  input  logic                issue_i,
  input  logic                last_i,
  input  logic [PW-1:0]       next_ptr_i,
  output logic                valid_o,
  output logic [WORDS*WW-1:0] words_o,
  output logic [PW-1:0]       ptr_o
);
  logic          valid_q, valid_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          state_en;

  // Next state: a load wins over a flush, and a flush wins over advancing.
  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (load_i) begin
      valid_d = 1'b1;
      ptr_d   = start_i;
    end else if (flush_i) begin
      valid_d = 1'b0;
    end else if (issue_i) begin
      if (last_i) valid_d = 1'b0;
      else        ptr_d   = next_ptr_i;
    end
  end

  assign state_en = load_i | flush_i | issue_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  // The data storage has no reset; it is qualified by valid_q.
  always_ff @(posedge clk) begin
    if (load_i) words_o <= words_i;
  end

  assign valid_o = valid_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/vd_group_find.sv
module vd_group_find #(
  parameter int unsigned WORDS = 8,
  localparam int unsigned PW   = $clog2(WORDS)
) (
  input  logic [WORDS-1:0] pbits_i,
  input  logic [PW-1:0]    ptr_i,
  output logic [WORDS-1:0] mask_o,
  output logic             last_o,
  output logic [PW-1:0]    next_ptr_o
);
  // The group runs from ptr_i up to the first word whose chaining bit is
  // clear. The walk stops at the top word whatever that word's bit holds.
  always_comb begin
    logic open;
    open       = 1'b1;
    mask_o     = '0;
    next_ptr_o = '0;
    for (int i = 0; i < int'(WORDS); i++) begin
      if ((PW'(i) >= ptr_i) && open) begin
        mask_o[i]  = 1'b1;
        next_ptr_o = PW'(i + 1);
        if (!pbits_i[i]) open = 1'b0;
      end
    end
  end

  assign last_o = mask_o[WORDS-1];
endmodule

// File: rtl/vd_unit_router.sv
module vd_unit_router #(
  parameter int unsigned WORDS    = 8,
  parameter int unsigned WW       = 32,
  parameter int unsigned NUNITS   = 8,
  parameter int unsigned USEL_LSB = 1,
  localparam int unsigned USEL_W  = $clog2(NUNITS)
) (
  input  logic [WORDS*WW-1:0]  words_i,
  input  logic [WORDS-1:0]     mask_i,
  output logic [NUNITS-1:0]    slot_valid_o,
  output logic [NUNITS*WW-1:0] slot_word_o,
  output logic                 conflict_o
);
  // Words are visited in rising order, so the lowest index keeps a slot
  // that more than one word asks for.
  always_comb begin
    logic [USEL_W-1:0] sel;
    slot_valid_o = '0;
    slot_word_o  = '0;
    conflict_o   = 1'b0;
    for (int i = 0; i < int'(WORDS); i++) begin
      sel = words_i[i*WW + USEL_LSB +: USEL_W];
      if (mask_i[i]) begin
        if (slot_valid_o[sel]) begin
          conflict_o = 1'b1;
        end else begin
          slot_valid_o[sel]              = 1'b1;
          slot_word_o[int'(sel)*WW +: WW] = words_i[i*WW +: WW];
        end
      end
    end
  end
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch #(
  parameter int unsigned WORDS    = 8,
  parameter int unsigned WW       = 32,
  parameter int unsigned NUNITS   = 8,
  parameter int unsigned USEL_LSB = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fp_valid_i,
  output logic                    fp_ready_o,
  input  logic [WORDS*WW-1:0]     fp_words_i,
  input  logic [$clog2(WORDS)-1:0] fp_start_i,
  input  logic                    redirect_i,
  output logic [NUNITS-1:0]       slot_valid_o,
  output logic [NUNITS*WW-1:0]    slot_word_o,
  output logic                    conflict_o
);
  import vd_pkg::*;

  localparam int unsigned PW = $clog2(WORDS);

  logic                 rst_s;
  logic                 buf_valid;
  logic [WORDS*WW-1:0]  buf_words;
  logic [PW-1:0]        buf_ptr;
  logic [WORDS-1:0]     pbits;
  logic [WORDS-1:0]     grp_mask;
  logic                 grp_last;
  logic [PW-1:0]        grp_next;
  logic [NUNITS-1:0]    r_valid;
  logic [NUNITS*WW-1:0] r_word;
  logic                 r_conflict;
  logic                 issue;
  logic                 load;

  vd_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  assign issue      = buf_valid & ~redirect_i;
  assign fp_ready_o = rst_s & (~buf_valid | grp_last | redirect_i);
  assign load       = fp_valid_i & fp_ready_o;

  vd_packet_buf #(.WORDS(WORDS), .WW(WW)) u_buf (
    .clk        (clk),
    .rst_ni     (rst_s),
    .load_i     (load),
    .words_i    (fp_words_i),
    .start_i    (fp_start_i),
    .flush_i    (redirect_i),
    .issue_i    (issue),
    .last_i     (grp_last),
    .next_ptr_i (grp_next),
    .valid_o    (buf_valid),
    .words_o    (buf_words),
    .ptr_o      (buf_ptr)
  );

  for (genvar g = 0; g < int'(WORDS); g++) begin : g_pbit
    assign pbits[g] = buf_words[g*WW + PBIT_POS];
  end

  vd_group_find #(.WORDS(WORDS)) u_find (
    .pbits_i    (pbits),
    .ptr_i      (buf_ptr),
    .mask_o     (grp_mask),
    .last_o     (grp_last),
    .next_ptr_o (grp_next)
  );

  vd_unit_router #(
    .WORDS(WORDS), .WW(WW), .NUNITS(NUNITS), .USEL_LSB(USEL_LSB)
  ) u_route (
    .words_i      (buf_words),
    .mask_i       (grp_mask),
    .slot_valid_o (r_valid),
    .slot_word_o  (r_word),
    .conflict_o   (r_conflict)
  );

  // Output stage: the valid and conflict flags are cleared in any cycle
  // that dispatches nothing.
  logic [NUNITS-1:0] sv_d;
  logic              cf_d;

  always_comb begin
    sv_d = issue ? r_valid : '0;
    cf_d = issue & r_conflict;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      slot_valid_o <= '0;
      conflict_o   <= 1'b0;
    end else begin
      slot_valid_o <= sv_d;
      conflict_o   <= cf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) slot_word_o <= r_word;
  end

  // Checks on the buffer, the group finder and the output stage.
  assert_empty_ready_R7: assert property (@(posedge clk) disable iff (!rst_s)
    !buf_valid |-> fp_ready_o);

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !issue |=> (slot_valid_o == '0) && !conflict_o);

  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (redirect_i && !load) |=> !buf_valid);

  assert_conflict_has_slot_R6: assert property (@(posedge clk) disable iff (!rst_s)
    conflict_o |-> (slot_valid_o != '0));

  assert_ptr_forward_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (issue && !grp_last && !load) |=> buf_valid && (buf_ptr > $past(buf_ptr)));

  assert_last_empties_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (issue && grp_last && !load) |=> !buf_valid);
endmodule

// File: tb/vliw_dispatch_tb_top.sv
`timescale 1ns/1ps
module vliw_dispatch_tb_top;
  logic         clk;
  logic         rst_n;
  logic         fp_valid_i;
  logic         fp_ready_o;
  logic [255:0] fp_words_i;
  logic [2:0]   fp_start_i;
  logic         redirect_i;
  logic [7:0]   slot_valid_o;
  logic [255:0] slot_word_o;
  logic         conflict_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  vliw_dispatch dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fp_valid_i   (fp_valid_i),
    .fp_ready_o   (fp_ready_o),
    .fp_words_i   (fp_words_i),
    .fp_start_i   (fp_start_i),
    .redirect_i   (redirect_i),
    .slot_valid_o (slot_valid_o),
    .slot_word_o  (slot_word_o),
    .conflict_o   (conflict_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Each entry is {start[2:0], eight nibbles}. Nibble i = {unit[2:0], chain}.
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 32'hECA86420},  // all single-word groups, units 0..7
    {3'd0, 32'h13579BDF},  // one eight-word group, word 7 chain bit set
    {3'd0, 32'hFDB87431},  // groups {0,1,2} {3,4} {5,6,7}
    {3'd5, 32'h531FDB87},  // start at word 5
    {3'd0, 32'hE0892655},  // repeated units inside groups
    {3'd7, 32'hD0000000}   // start on the last word
  };

  function automatic logic [255:0] build(input int v, input logic [34:0] e);
    logic [255:0] w;
    for (int i = 0; i < 8; i++)
      w[i*32 +: 32] = {4'(v), 4'(i), 20'h5A5A5, e[i*4 +: 4]};
    return w;
  endfunction

  function automatic logic [7:0] grp(input logic [255:0] w, input int p);
    logic [7:0] m;
    logic open;
    m = '0;
    open = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i >= p && open) begin
        m[i] = 1'b1;
        if (!w[i*32]) open = 1'b0;
      end
    end
    return m;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compares the presented group with the one expected from words w
  // starting at p, and checks fetch readiness.
  task automatic check_group(input logic [255:0] w, input int p,
                             input string req, output int nxt, output bit last);
    logic [7:0]   m, ev, mn;
    logic [255:0] ew;
    logic         ec, er;
    int           u;
    m  = grp(w, p);
    ev = '0; ew = '0; ec = 1'b0; nxt = p;
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        u = int'(w[i*32+1 +: 3]);
        if (ev[u]) ec = 1'b1;
        else begin ev[u] = 1'b1; ew[u*32 +: 32] = w[i*32 +: 32]; end
        nxt = i + 1;
      end
    end
    last = m[7];
    if (last) er = 1'b1;
    else begin mn = grp(w, nxt); er = mn[7]; end
    for (int k = 0; k < 8; k++)
      if (!ev[k]) ew[k*32 +: 32] = 'x;
    chk(slot_valid_o == ev, {req, " R2 R4 slot valid"}, 256'(slot_valid_o), 256'(ev));
    begin
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < 8; k++)
        if (ev[k] && slot_word_o[k*32 +: 32] !== ew[k*32 +: 32]) ok = 1'b0;
      chk(ok, {req, " R4 slot words"}, slot_word_o, ew);
    end
    chk(conflict_o == ec, {req, " R6 conflict"}, 256'(conflict_o), 256'(ec));
    chk(fp_ready_o == er, {req, " R7 ready"}, 256'(fp_ready_o), 256'(er));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] w;
    int  p, nxt;
    bit  last;
    rst_n = 1'b0; fp_valid_i = 1'b0; fp_words_i = '0;
    fp_start_i = '0; redirect_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(slot_valid_o == 8'h00, "R1 slot valid after reset", 256'(slot_valid_o), 256'h0);
    chk(conflict_o == 1'b0, "R1 conflict after reset", 256'(conflict_o), 256'h0);
    chk(fp_ready_o == 1'b1, "R1 ready after reset", 256'(fp_ready_o), 256'h1);

    // Table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      w = build(v, VEC[v]);
      @(negedge clk);
      chk(fp_ready_o == 1'b1, "R7 ready when empty", 256'(fp_ready_o), 256'h1);
      fp_valid_i = 1'b1; fp_words_i = w; fp_start_i = VEC[v][34:32];
      @(negedge clk);
      fp_valid_i = 1'b0;
      chk(slot_valid_o == 8'h00, "R9 nothing issued on load edge",
          256'(slot_valid_o), 256'h0);
      p = int'(VEC[v][34:32]);
      last = 1'b0;
      while (!last) begin
        @(negedge clk);
        check_group(w, p, "table", nxt, last);
        p = nxt;
      end
      @(negedge clk);
      chk(slot_valid_o == 8'h00, "R9 R5 quiet after packet", 256'(slot_valid_o), 256'h0);
      chk(conflict_o == 1'b0, "R9 conflict cleared", 256'(conflict_o), 256'h0);
    end

    // R8: redirect flushes the remaining groups
    w = build(10, VEC[0]);
    @(negedge clk);
    fp_valid_i = 1'b1; fp_words_i = w; fp_start_i = 3'd0;
    @(negedge clk);
    fp_valid_i = 1'b0;
    @(negedge clk);
    check_group(w, 0, "pre-flush", nxt, last);
    redirect_i = 1'b1;
    @(negedge clk);
    redirect_i = 1'b0;
    chk(slot_valid_o == 8'h00, "R8 no issue on redirect", 256'(slot_valid_o), 256'h0);
    chk(fp_ready_o == 1'b1, "R8 R7 ready after flush", 256'(fp_ready_o), 256'h1);
    @(negedge clk);
    chk(slot_valid_o == 8'h00, "R8 flushed groups not issued", 256'(slot_valid_o), 256'h0);

    // R8: redirect together with a new packet that starts at word 7
    w = build(11, VEC[2]);
    @(negedge clk);
    fp_valid_i = 1'b1; fp_words_i = w; fp_start_i = 3'd0;
    @(negedge clk);
    fp_valid_i = 1'b0;
    @(negedge clk);
    check_group(w, 0, "pre-redirect", nxt, last);
    w = build(12, VEC[5]);
    redirect_i = 1'b1; fp_valid_i = 1'b1; fp_words_i = w; fp_start_i = 3'd7;
    @(negedge clk);
    redirect_i = 1'b0; fp_valid_i = 1'b0;
    chk(slot_valid_o == 8'h00, "R8 redirect edge quiet", 256'(slot_valid_o), 256'h0);
    @(negedge clk);
    check_group(w, 7, "R8 R5 redirect target", nxt, last);
    chk(slot_valid_o == 8'h40, "R8 target word in M2 slot", 256'(slot_valid_o), 256'h40);
    @(negedge clk);

    // R7: back-to-back packet accepted during the final group
    w = build(13, VEC[1]);
    @(negedge clk);
    fp_valid_i = 1'b1; fp_words_i = w; fp_start_i = 3'd0;
    @(negedge clk);
    chk(fp_ready_o == 1'b1, "R7 ready during final group", 256'(fp_ready_o), 256'h1);
    fp_words_i = build(14, VEC[0]); fp_start_i = 3'd0;
    @(negedge clk);
    fp_valid_i = 1'b0;
    chk(slot_valid_o == 8'hFF, "R3 full group issued", 256'(slot_valid_o), 256'hFF);
    @(negedge clk);
    chk(slot_valid_o == 8'h01, "R7 next packet follows at once",
        256'(slot_valid_o), 256'h01);
    repeat (10) @(negedge clk);
    chk(slot_valid_o == 8'h00, "R9 drained", 256'(slot_valid_o), 256'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule